// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This unit watches a processor's instruction fetches and data accesses and raises a breakpoint request when one of them hits an address programmed into a trigger slot. Each slot holds a control word and a compare value. The slot fires when three things hold at once: its activity kind is enabled, its privilege enables accept the current privilege level, and the address falls on the compare value. For data accesses the slot matches any address inside a window whose length comes from a size code.

The only action is a breakpoint request. It is presented as a one-cycle pulse, together with the index of the slot that caused it, so that the core can stop before the instruction or access completes. There are two slot flavours, selected by the type code in the control word. The basic flavour checks only the machine, supervisor and user enables and stays silent whenever virtualization is active. The extended flavour adds separate enables for virtual user and virtual supervisor modes. The unit also reports, per slot, whether the slot is armed.

Slots are programmed through a single-cycle write port. The port selects a slot and either the control word or the compare value.

Top module: `brkpt_match_unit`

## Requirements
- R1: `armed_o[i]` is 1 exactly when three conditions hold: slot i has type code 2 or 6 (control bits [XLEN-1:XLEN-4]); at least one of its execute (bit 2), store (bit 1) or load (bit 0) enables is set; and at least one privilege enable is set. The privilege enables are U (bit 3), S (bit 4) and M (bit 6), plus VU (bit 23) and VS (bit 24) for type 6.
- R2: An execute hit needs `fetch_vld_i` high, the execute enable set, and `fetch_pc_i` exactly equal to the compare value.
- R3: A data hit needs `data_vld_i` high, and the store enable set when `data_store_i`=1 or the load enable set when it is 0. The address must satisfy compare <= `data_addr_i` <= compare + span - 1.
- R4: The size code is control bits [19:16] for type 6 and bits [17:16] for type 2. Codes 1, 2, 3 and 5 give spans of 1, 2, 4 and 8 bytes. Code 0 and every other code give an 8-byte span.
- R5: With `virt_i`=0, a hit is qualified by control bit 3+`priv_i`, where priv encodes U=0, S=1 and M=3. Privilege code 2 never qualifies.
- R6: With `virt_i`=1, a type-6 slot is qualified by bit 23+`priv_i` for priv 0 (VU) or 1 (VS). Any other priv never qualifies, and a type-2 slot never fires.
- R7: `fire_o` is high for exactly one cycle following each cycle in which some slot hits. Hits are evaluated against the slot contents held before a write in that same cycle takes effect.
- R8: When several slots hit in one cycle, `fire_slot_o` gives the lowest index among them.
- R9: Reset clears every control word and compare value, so all slots read as unarmed and nothing fires. A write with `cfg_field_i`=0 loads the control word of slot `cfg_slot_i`, and a write with 1 loads its compare value.
- R10: A slot whose type code is neither 2 nor 6 never arms and never fires, whatever its other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Slot register write strobe |
| cfg_slot_i | input | SLOT_W | Slot selected for the write |
| cfg_field_i | input | 1 | 0 = control word, 1 = compare value |
| cfg_data_i | input | XLEN | Write data |
| fetch_vld_i | input | 1 | Instruction fetch valid |
| fetch_pc_i | input | XLEN | Fetch address |
| data_vld_i | input | 1 | Data access valid |
| data_addr_i | input | XLEN | Data access address |
| data_store_i | input | 1 | 1 = store, 0 = load |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization active |
| fire_o | output | 1 | Breakpoint request pulse |
| fire_slot_o | output | SLOT_W | Index of the firing slot |
| armed_o | output | NSLOT | Per-slot armed flag |

## Verification
Fetches are tried on, and one step off, the compare value, which separates the exact-match rule from the window rule. Data accesses are tried on the first and last byte of each span and one byte beyond each end, under several size codes including zero and an unsupported code, which separates the span decode entries. The same enabled slot is then exercised across every privilege level with virtualization both off and on, which separates the two qualification bit sets and the type-2 suppression. Finally both slots are made to hit at once, a write is placed in the same cycle as a hit, and an unknown type code is loaded, which exposes priority, write ordering and the inert type.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int LD_BIT    = 0;
  localparam int ST_BIT    = 1;
  localparam int EX_BIT    = 2;
  localparam int PRV_BASE  = 3;
  localparam int VPRV_BASE = 23;
  localparam int SZ_LSB    = 16;
  localparam int TYPE_W    = 4;

  typedef enum logic [1:0] {KIND_NONE, KIND_T2, KIND_T6} slot_kind_e;

  // decode type code into slot flavour
  function automatic slot_kind_e kind_of(logic [TYPE_W-1:0] code);
    slot_kind_e k;
    case (code)
      4'd2:    k = KIND_T2;
      4'd6:    k = KIND_T6;
      default: k = KIND_NONE;
    endcase
    return k;
  endfunction

  // bytes covered by a data watch for a given size code
  function automatic logic [3:0] span_bytes(logic [3:0] code);
    logic [3:0] n;
    case (code)
      4'd1:    n = 4'd1;
      4'd2:    n = 4'd2;
      4'd3:    n = 4'd4;
      4'd5:    n = 4'd8;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

  // privilege qualification; msu = {M,S,U} enables, vsvu = {VS,VU} enables
  function automatic logic priv_ok(slot_kind_e k, logic [2:0] msu,
                                   logic [1:0] vsvu, logic [1:0] prv,
                                   logic virt);
    logic ok;
    ok = 1'b0;
    if (k != KIND_NONE) begin
      if (!virt) begin
        case (prv)
          2'd0:    ok = msu[0];
          2'd1:    ok = msu[1];
          2'd3:    ok = msu[2];
          default: ok = 1'b0;
        endcase
      end else if (k == KIND_T6) begin
        case (prv)
          2'd0:    ok = vsvu[0];
          2'd1:    ok = vsvu[1];
          default: ok = 1'b0;
        endcase
      end
    end
    return ok;
  endfunction
endpackage

// File: rtl/brk_slot.sv
module brk_slot
  import brk_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_cmp,
  input  logic [XLEN-1:0] wdata,
  input  logic            fetch_vld,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            data_vld,
  input  logic [XLEN-1:0] data_addr,
  input  logic            data_store,
  input  logic [1:0]      priv,
  input  logic            virt,
  output logic            armed,
  output logic            hit,
  output logic            is_t6
);
  logic [XLEN-1:0] ctrl_q, cmp_q;
  slot_kind_e      kind;
  logic [2:0]      msu_en;
  logic [1:0]      vsvu_en;
  logic [3:0]      sz_code;
  logic [3:0]      span;
  logic            kind_en, exec_hit, data_hit, prv_hit;

  function automatic logic in_window(logic [XLEN-1:0] a, logic [XLEN-1:0] base,
                                     logic [3:0] n);
    logic [XLEN-1:0] off;
    off = a - base;
    return off < XLEN'(n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_cmp)  cmp_q  <= wdata;
    end
  end

  always_comb begin
    kind    = kind_of(ctrl_q[XLEN-1 -: TYPE_W]);
    msu_en  = {ctrl_q[PRV_BASE+3], ctrl_q[PRV_BASE+1], ctrl_q[PRV_BASE]};
    vsvu_en = (kind == KIND_T6) ? {ctrl_q[VPRV_BASE+1], ctrl_q[VPRV_BASE]} : 2'b00;
    sz_code = (kind == KIND_T6) ? ctrl_q[SZ_LSB+3:SZ_LSB]
                                : {2'b00, ctrl_q[SZ_LSB+1:SZ_LSB]};
    span    = span_bytes(sz_code);
    kind_en = data_store ? ctrl_q[ST_BIT] : ctrl_q[LD_BIT];
    exec_hit = fetch_vld && ctrl_q[EX_BIT] && (fetch_pc == cmp_q);
    data_hit = data_vld && kind_en && in_window(data_addr, cmp_q, span);
    prv_hit  = priv_ok(kind, msu_en, vsvu_en, priv, virt);
  end

  assign armed = (kind != KIND_NONE) && ((|msu_en) || (|vsvu_en)) &&
                 (|ctrl_q[EX_BIT:LD_BIT]);
  assign hit   = prv_hit && (exec_hit || data_hit);
  assign is_t6 = (kind == KIND_T6);
endmodule

// File: rtl/brk_pick.sv
module brk_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/brkpt_match_unit.sv
module brkpt_match_unit #(
  parameter  int NSLOT  = 2,
  parameter  int XLEN   = 32,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic              cfg_field_i,
  input  logic [XLEN-1:0]   cfg_data_i,
  input  logic              fetch_vld_i,
  input  logic [XLEN-1:0]   fetch_pc_i,
  input  logic              data_vld_i,
  input  logic [XLEN-1:0]   data_addr_i,
  input  logic              data_store_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  output logic              fire_o,
  output logic [SLOT_W-1:0] fire_slot_o,
  output logic [NSLOT-1:0]  armed_o
);
  logic [NSLOT-1:0]  slot_hit;
  logic [NSLOT-1:0]  slot_is_t6;
  logic              hit_any;
  logic [SLOT_W-1:0] hit_idx;
  logic              fire_q;
  logic [SLOT_W-1:0] slot_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic sel;
    assign sel = cfg_we_i && (cfg_slot_i == SLOT_W'(g));
    brk_slot #(.XLEN(XLEN)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (sel && !cfg_field_i),
      .wr_cmp     (sel &&  cfg_field_i),
      .wdata      (cfg_data_i),
      .fetch_vld  (fetch_vld_i),
      .fetch_pc   (fetch_pc_i),
      .data_vld   (data_vld_i),
      .data_addr  (data_addr_i),
      .data_store (data_store_i),
      .priv       (priv_i),
      .virt       (virt_i),
      .armed      (armed_o[g]),
      .hit        (slot_hit[g]),
      .is_t6      (slot_is_t6[g])
    );
  end

  brk_pick #(.N(NSLOT), .IW(SLOT_W)) u_pick (
    .hits (slot_hit),
    .any  (hit_any),
    .idx  (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      slot_q <= '0;
    end else begin
      fire_q <= hit_any;
      slot_q <= hit_any ? hit_idx : '0;
    end
  end

  assign fire_o      = fire_q;
  assign fire_slot_o = slot_q;
endmodule

// File: rtl/brkpt_match_unit_chk.sv
module brkpt_match_unit_chk #(
  parameter int NSLOT  = 2,
  parameter int SLOT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_vld,
  input logic              data_vld,
  input logic              virt,
  input logic [NSLOT-1:0]  slot_hit,
  input logic [NSLOT-1:0]  slot_is_t6,
  input logic [NSLOT-1:0]  armed,
  input logic              hit_any,
  input logic              fire,
  input logic [SLOT_W-1:0] fire_slot
);
  AST_FIRE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> fire); // R7
  AST_QUIET_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> !fire); // R7
  AST_FIRE_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((($past(slot_hit) >> fire_slot) & NSLOT'(1)) != '0)); // R8
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (($past(slot_hit) & ((NSLOT'(1) << fire_slot) - NSLOT'(1))) == '0)); // R8
  AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit & ~armed) == '0); // R1
  AST_T2_QUIET_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    virt |-> ((slot_hit & ~slot_is_t6) == '0)); // R6
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_hit) |-> (fetch_vld || data_vld)); // R2
endmodule

bind brkpt_match_unit brkpt_match_unit_chk #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_vld  (fetch_vld_i),
  .data_vld   (data_vld_i),
  .virt       (virt_i),
  .slot_hit   (slot_hit),
  .slot_is_t6 (slot_is_t6),
  .armed      (armed_o),
  .hit_any    (hit_any),
  .fire       (fire_o),
  .fire_slot  (fire_slot_o)
);

// File: tb/sim_brkpt_match_unit.sv
module sim_brkpt_match_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_slot = '0;
  logic        cfg_field = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        data_vld = 1'b0;
  logic [31:0] data_addr = '0;
  logic        data_store = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic        fire;
  logic [0:0]  fire_slot;
  logic [1:0]  armed;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_ctrl [NS];
  logic [31:0] m_cmp  [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  brkpt_match_unit #(.NSLOT(NS), .XLEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_slot_i(cfg_slot),
    .cfg_field_i(cfg_field), .cfg_data_i(cfg_data), .fetch_vld_i(fetch_vld),
    .fetch_pc_i(fetch_pc), .data_vld_i(data_vld), .data_addr_i(data_addr),
    .data_store_i(data_store), .priv_i(priv), .virt_i(virt),
    .fire_o(fire), .fire_slot_o(fire_slot), .armed_o(armed)
  );

  function automatic int m_type(int s);
    return int'(m_ctrl[s][31:28]);
  endfunction

  function automatic bit m_armed(int s);
    int t;
    bit any_prv, any_kind;
    t = m_type(s);
    if (t != 2 && t != 6) return 0;
    any_prv = m_ctrl[s][3] | m_ctrl[s][4] | m_ctrl[s][6];
    if (t == 6) any_prv = any_prv | m_ctrl[s][23] | m_ctrl[s][24];
    any_kind = m_ctrl[s][0] | m_ctrl[s][1] | m_ctrl[s][2];
    return any_prv && any_kind;
  endfunction

  function automatic longint m_span(int s);
    int code;
    code = (m_type(s) == 6) ? int'(m_ctrl[s][19:16]) : int'(m_ctrl[s][17:16]);
    if (code == 1) return 1;
    if (code == 2) return 2;
    if (code == 3) return 4;
    return 8;
  endfunction

  function automatic bit m_qual(int s);
    int t;
    t = m_type(s);
    if (t != 2 && t != 6) return 0;
    if (!virt) begin
      if (priv == 2) return 0;
      return m_ctrl[s][3 + priv];
    end
    if (t != 6 || priv > 1) return 0;
    return m_ctrl[s][23 + priv];
  endfunction

  function automatic bit m_hit(int s);
    bit ex, dt;
    longint lo, a;
    ex = fetch_vld && m_ctrl[s][2] && (fetch_pc == m_cmp[s]);
    lo = longint'(m_cmp[s]);
    a  = longint'(data_addr);
    dt = data_vld && (data_store ? m_ctrl[s][1] : m_ctrl[s][0]) &&
         (a >= lo) && (a <= lo + m_span(s) - 1);
    return m_qual(s) && (ex || dt);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one clock: predict, advance, apply write to model, compare
  task automatic tick(string tag);
    bit exp_fire;
    int exp_slot;
    logic [1:0] exp_armed;
    exp_fire = 0;
    exp_slot = 0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (m_hit(s)) begin
        exp_fire = 1;
        exp_slot = s;
      end
    end
    @(posedge clk);
    if (cfg_we) begin
      if (cfg_field) m_cmp[cfg_slot] = cfg_data;
      else           m_ctrl[cfg_slot] = cfg_data;
    end
    @(negedge clk);
    for (int s = 0; s < NS; s++) exp_armed[s] = m_armed(s);
    checks++;
    if (fire !== exp_fire || (exp_fire && int'(fire_slot) != exp_slot)) begin
      fails++;
      $display("FAIL %s fire/slot: got %0b/%0d expected %0b/%0d",
               tag, fire, fire_slot, exp_fire, exp_slot);
    end
    checks++;
    if (armed !== exp_armed) begin
      fails++;
      $display("FAIL %s armed: got %b expected %b", tag, armed, exp_armed);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; fetch_vld = 0; data_vld = 0;
  endtask

  task automatic wr(int s, bit fld, logic [31:0] d, string tag);
    idle_inputs();
    cfg_we = 1; cfg_slot = 1'(s); cfg_field = fld; cfg_data = d;
    tick(tag);
    cfg_we = 0;
  endtask

  task automatic fetch(logic [31:0] pc, string tag);
    idle_inputs();
    fetch_vld = 1; fetch_pc = pc;
    tick(tag);
    fetch_vld = 0;
  endtask

  task automatic access(logic [31:0] a, bit st, string tag);
    idle_inputs();
    data_vld = 1; data_addr = a; data_store = st;
    tick(tag);
    data_vld = 0;
  endtask

  localparam logic [31:0] T2 = 32'h2000_0000, T6 = 32'h6000_0000;
  localparam logic [31:0] BU = 32'h8, BS = 32'h10, BM = 32'h40;
  localparam logic [31:0] BVU = 32'h80_0000, BVS = 32'h100_0000;
  localparam logic [31:0] BLD = 32'h1, BST = 32'h2, BEX = 32'h4;

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_ctrl[s] = '0; m_cmp[s] = '0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (fire !== 1'b0 || armed !== 2'b00) begin
      fails++;
      $display("FAIL R9 reset: fire=%b armed=%b expected 0/00", fire, armed);
    end
    rst_n = 1;
    fetch(32'h0, "R9");
    // R2 / R5: execute, exact address, machine mode
    wr(0, 1, 32'h1000, "R9");
    wr(0, 0, T2 | BM | BEX, "R1");
    priv = 3;
    fetch(32'h1000, "R2");
    fetch(32'h1004, "R2");
    fetch(32'h0FFF, "R2");
    priv = 0; fetch(32'h1000, "R5");
    priv = 1; fetch(32'h1000, "R5");
    priv = 2; fetch(32'h1000, "R5");
    // R1: enables without kind bits, kind bits without enables
    wr(0, 0, T2 | BM | BS | BU, "R1");
    wr(0, 0, T2 | BEX, "R1");
    wr(0, 0, T6 | BVS | BLD, "R1");
    // R3 / R4: type-2 load window of 4 bytes
    priv = 3;
    wr(0, 1, 32'h2000, "R9");
    wr(0, 0, T2 | BM | BLD | (32'd3 << 16), "R4");
    access(32'h2000, 0, "R3");
    access(32'h2003, 0, "R4");
    access(32'h2004, 0, "R4");
    access(32'h1FFF, 0, "R4");
    access(32'h2001, 1, "R3");
    // size 0 -> 8 bytes
    wr(0, 0, T2 | BM | BLD | BST, "R4");
    access(32'h2007, 1, "R4");
    access(32'h2008, 0, "R4");
    // type 6 sizes: code 2, code 5, unsupported code 7
    wr(1, 1, 32'h3000, "R9");
    wr(1, 0, T6 | BU | BST | (32'd2 << 16), "R4");
    priv = 0;
    access(32'h3001, 1, "R4");
    access(32'h3002, 1, "R4");
    wr(1, 0, T6 | BU | BST | (32'd5 << 16), "R4");
    access(32'h3007, 1, "R4");
    access(32'h3008, 1, "R4");
    wr(1, 0, T6 | BU | BST | (32'd7 << 16), "R4");
    access(32'h3007, 1, "R4");
    access(32'h3000, 0, "R3");
    // R6: virtualization
    wr(0, 0, T2 | BU | BS | BM | BEX, "R6");
    wr(0, 1, 32'h4000, "R6");
    wr(1, 1, 32'h4000, "R6");
    wr(1, 0, T6 | BU | BS | BM | BEX, "R6");
    virt = 1;
    for (int p = 0; p < 4; p++) begin priv = 2'(p); fetch(32'h4000, "R6"); end
    wr(1, 0, T6 | BVU | BEX, "R6");
    priv = 0; fetch(32'h4000, "R6");
    priv = 1; fetch(32'h4000, "R6");
    wr(1, 0, T6 | BVS | BEX, "R6");
    fetch(32'h4000, "R6");
    priv = 3; fetch(32'h4000, "R6");
    virt = 0;
    // R8: both slots hit, lowest wins; then only slot 1
    wr(1, 0, T6 | BM | BEX, "R8");
    fetch(32'h4000, "R8");
    wr(0, 1, 32'h5000, "R8");
    fetch(32'h4000, "R8");
    // R7: back-to-back strobes, then a gap
    idle_inputs(); fetch_vld = 1; fetch_pc = 32'h4000;
    tick("R7"); tick("R7"); tick("R7");
    idle_inputs(); tick("R7"); tick("R7");
    // R7: write in same cycle as a hit uses old contents
    idle_inputs(); fetch_vld = 1; fetch_pc = 32'h4000;
    cfg_we = 1; cfg_slot = 1; cfg_field = 1; cfg_data = 32'h6000;
    tick("R7");
    idle_inputs();
    fetch(32'h4000, "R7");
    fetch(32'h6000, "R7");
    // R10: unknown type code is inert
    wr(1, 0, 32'h5000_0000 | BU | BS | BM | BLD | BST | BEX, "R10");
    fetch(32'h6000, "R10");
    access(32'h6000, 0, "R10");
    wr(0, 0, 32'hF000_0000 | BM | BEX, "R10");
    wr(0, 1, 32'h6000, "R10");
    fetch(32'h6000, "R10");
    finish_run();
  end
endmodule